// File: doc/BRIEF.md
# Serial Two-Byte Command Decoder

This block takes 8-bit words from a three-wire serial link (an active-low select, a serial clock and serial data) and turns them into the settings of an on-screen display engine. A word with its top bit set is a command. The command's identity is held, so any number of data words that follow are applied to that same command. The decoder loads a write address, vertical and horizontal start offsets, a control flag set, a display-mode set, two twelve-row masks (second-channel routing and double size) and a 4-bit general-purpose output port.

One command switches the decoder into a character-stream mode. In that mode every further word becomes a video RAM write: the top bit is the attribute and the low seven bits are the character code. The write column steps forward by one after each write and wraps to column 0 of the next row. The stream ends only when the select line is released. Releasing select also puts the decoder back into address-setup mode. The link inputs are synchronised into the system clock domain, so the serial clock must be much slower than the system clock. The RAM and the display timing logic are not part of this block.

Top module: `osd_serial_cmd`

## Requirements
- R1: Data is shifted in most significant bit first, on rising serial-clock edges seen while select is low. Every eighth bit completes a word. A partial word is dropped when select goes high, so the next word starts from a fresh bit count.
- R2: A word with bit 7 = 1 is a command, and its identity is bits 6:4. A word with bit 7 = 0 is data for the most recent command.
- R3: The command identity stays in force across any number of data words until the next command word arrives.
- R4: Command 0 (bits 6:4 = 0) loads the write row from command bits 3:0. Its data word loads the write column from bits 4:0.
- R5: Command 1 (0x90) enters stream mode. Every later word, including one with bit 7 set, produces one RAM write strobe: attribute = bit 7, code = bits 6:0, at the current row and column. No other register changes.
- R6: After each stream write the column increments. Column 23 wraps to column 0 of the next row, and row 11 wraps to row 0.
- R7: A rising edge on select ends stream mode and selects command 0, so the next data word loads the column and the next command word is decoded normally.
- R8: The data word of command 2 (0xA0) loads the 6-bit vertical start from bits 5:0. The data word of command 3 (0xB0) loads the 6-bit horizontal start from bits 5:0.
- R9: Command 4 (0xC0) loads the control flags from command bits 3:0: bit 3 test, bit 2 RAM clear, bit 1 oscillator stop, bit 0 system reset. Its data word loads the display mode from bits 6:0: bit 6 blank mode, bit 5 channel-1 mode, bit 4 border, bit 3 blink period, bit 2 blink, bit 1 reverse, bit 0 display on.
- R10: Command 5 (0xD0 | S) stores select bit S from command bit 0. Its data bits 5:0 load mask rows 1 to 6 (mask bits 5:0). The data bits 5:0 of command 6 load rows 7 to 12 (mask bits 11:6). When S = 0 the routing mask is written; when S = 1 the double-size mask is written.
- R11: Command 6 (0xE0 | P) loads the general-purpose port from command bits 3:0. The port changes only when a word is decoded.
- R12: An active-low reset clears every output register to zero.
- R13: Data words under command 7 (0xF0) change no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_sel_n | input | 1 | Serial select, active low |
| ser_clk | input | 1 | Serial bit clock |
| ser_dat | input | 1 | Serial data, MSB first |
| vram_we | output | 1 | One-cycle video RAM write strobe |
| vram_row | output | 4 | Write row |
| vram_col | output | 5 | Write column |
| vram_code | output | 7 | Character code |
| vram_attr | output | 1 | Character attribute |
| vstart | output | 6 | Vertical start offset |
| hstart | output | 6 | Horizontal start offset |
| ctl_flags | output | 4 | Test, RAM clear, oscillator stop, system reset |
| disp_mode | output | 7 | Display mode bits |
| route_mask | output | 12 | Second-channel row routing mask |
| dbl_mask | output | 12 | Double-size row mask |
| gp_port | output | 4 | General-purpose output port |

## Verification
The bench sweeps every value of each data field: all 64 start offsets, all 128 display-mode words, and all 16 flag and port nibbles. Each sweep is sent as a single command followed by a run of data words, so a decoder that drops the command identity between words shows up at once. The mask sweeps use both values of the select bit and both halves of the mask, which separates a wrong mask from a wrong half. A partial word before a select release shows whether the bit count is cleared. In stream mode the bench sends codes with bit 7 set, from starting points that cross the column wrap and the row wrap. This separates stream writes from command decoding and checks both wraps. It then releases select to confirm that stream mode is left and command 0 is selected again.

// File: rtl/osd_cmd_pkg.sv
package osd_cmd_pkg;
  typedef enum logic [2:0] {
    CMD_ADDR   = 3'd0,
    CMD_CHAR   = 3'd1,
    CMD_VPOS   = 3'd2,
    CMD_HPOS   = 3'd3,
    CMD_CTRL   = 3'd4,
    CMD_MASKLO = 3'd5,
    CMD_MASKHI = 3'd6,
    CMD_NONE   = 3'd7
  } cmd_id_e;
endpackage

// File: rtl/osd_ser_shift.sv
module osd_ser_shift #(
  parameter int WORD_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_n,
  input  logic              sclk,
  input  logic              sdat,
  output logic              word_vld,
  output logic [WORD_W-1:0] word,
  output logic              sel_rel
);
  localparam int CNT_W = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WORD_W - 1);

  // each stage holds {select, clock, data}
  logic [2:0] sync_q [SYNC_STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q[0] <= 3'b100;
    else        sync_q[0] <= {sel_n, sclk, sdat};
  end

  for (genvar g = 1; g < SYNC_STAGES; g++) begin : g_sync
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q[g] <= 3'b100;
      else        sync_q[g] <= sync_q[g-1];
    end
  end

  logic s_sel, s_clk, s_dat;
  assign {s_sel, s_clk, s_dat} = sync_q[SYNC_STAGES-1];

  logic              clk_prev_q, sel_prev_q;
  logic [WORD_W-1:0] shreg_q, shreg_n, word_q, word_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic              vld_q, vld_n, rel_q, rel_n;

  always_comb begin
    shreg_n = shreg_q;
    cnt_n   = cnt_q;
    word_n  = word_q;
    vld_n   = 1'b0;
    rel_n   = s_sel & ~sel_prev_q;
    if (s_sel) begin
      cnt_n = '0;
    end else if (s_clk && !clk_prev_q) begin
      shreg_n = {shreg_q[WORD_W-2:0], s_dat};
      if (cnt_q == CNT_LAST) begin
        cnt_n  = '0;
        vld_n  = 1'b1;
        word_n = shreg_n;
      end else begin
        cnt_n = cnt_q + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_prev_q <= 1'b0;
      sel_prev_q <= 1'b1;
      shreg_q    <= '0;
      cnt_q      <= '0;
      word_q     <= '0;
      vld_q      <= 1'b0;
      rel_q      <= 1'b0;
    end else begin
      clk_prev_q <= s_clk;
      sel_prev_q <= s_sel;
      shreg_q    <= shreg_n;
      cnt_q      <= cnt_n;
      word_q     <= word_n;
      vld_q      <= vld_n;
      rel_q      <= rel_n;
    end
  end

  assign word_vld = vld_q;
  assign word     = word_q;
  assign sel_rel  = rel_q;

  // R1
  vld_rel_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(vld_q && rel_q));
endmodule

// File: rtl/osd_cmd_dec.sv
module osd_cmd_dec
  import osd_cmd_pkg::*;
#(
  parameter int ROWS   = 12,
  parameter int COLS   = 24,
  parameter int POS_W  = 6,
  parameter int MASK_W = 12,
  parameter int PORT_W = 4,
  localparam int ROW_W = $clog2(ROWS),
  localparam int COL_W = $clog2(COLS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              word_vld,
  input  logic [7:0]        word,
  input  logic              sel_rel,
  output logic              vram_we,
  output logic [ROW_W-1:0]  vram_row,
  output logic [COL_W-1:0]  vram_col,
  output logic [6:0]        vram_code,
  output logic              vram_attr,
  output logic [POS_W-1:0]  vstart,
  output logic [POS_W-1:0]  hstart,
  output logic [3:0]        ctl_flags,
  output logic [6:0]        disp_mode,
  output logic [MASK_W-1:0] route_mask,
  output logic [MASK_W-1:0] dbl_mask,
  output logic [PORT_W-1:0] gp_port
);
  localparam int HALF = MASK_W / 2;
  localparam logic [COL_W-1:0] COL_LAST = COL_W'(COLS - 1);
  localparam logic [ROW_W-1:0] ROW_LAST = ROW_W'(ROWS - 1);

  cmd_id_e           cmd_q, cmd_n;
  logic              lock_q, lock_n, sel_q, sel_n;
  logic [ROW_W-1:0]  row_q, row_n;
  logic [COL_W-1:0]  col_q, col_n;
  logic              we_q, we_n, attr_q, attr_n;
  logic [ROW_W-1:0]  wrow_q, wrow_n;
  logic [COL_W-1:0]  wcol_q, wcol_n;
  logic [6:0]        code_q, code_n;
  logic [POS_W-1:0]  vs_q, vs_n, hs_q, hs_n;
  logic [3:0]        flg_q, flg_n;
  logic [6:0]        mode_q, mode_n;
  logic [MASK_W-1:0] rt_q, rt_n, db_q, db_n;
  logic [PORT_W-1:0] port_q, port_n;

  always_comb begin
    cmd_n  = cmd_q;   lock_n = lock_q;  sel_n  = sel_q;
    row_n  = row_q;   col_n  = col_q;
    we_n   = 1'b0;    wrow_n = wrow_q;  wcol_n = wcol_q;
    code_n = code_q;  attr_n = attr_q;
    vs_n   = vs_q;    hs_n   = hs_q;    flg_n  = flg_q;
    mode_n = mode_q;  rt_n   = rt_q;    db_n   = db_q;
    port_n = port_q;
    if (sel_rel) begin
      cmd_n  = CMD_ADDR;
      lock_n = 1'b0;
    end else if (word_vld) begin
      if (lock_q) begin
        we_n   = 1'b1;
        wrow_n = row_q;
        wcol_n = col_q;
        code_n = word[6:0];
        attr_n = word[7];
        if (col_q == COL_LAST) begin
          col_n = '0;
          row_n = (row_q == ROW_LAST) ? '0 : row_q + ROW_W'(1);
        end else begin
          col_n = col_q + COL_W'(1);
        end
      end else if (word[7]) begin
        cmd_n = cmd_id_e'(word[6:4]);
        case (cmd_id_e'(word[6:4]))
          CMD_ADDR:   row_n  = word[ROW_W-1:0];
          CMD_CHAR:   lock_n = 1'b1;
          CMD_CTRL:   flg_n  = word[3:0];
          CMD_MASKLO: sel_n  = word[0];
          CMD_MASKHI: port_n = word[PORT_W-1:0];
          default: ;
        endcase
      end else begin
        case (cmd_q)
          CMD_ADDR: col_n  = word[COL_W-1:0];
          CMD_VPOS: vs_n   = word[POS_W-1:0];
          CMD_HPOS: hs_n   = word[POS_W-1:0];
          CMD_CTRL: mode_n = word[6:0];
          CMD_MASKLO: begin
            if (sel_q) db_n[HALF-1:0] = word[HALF-1:0];
            else       rt_n[HALF-1:0] = word[HALF-1:0];
          end
          CMD_MASKHI: begin
            if (sel_q) db_n[MASK_W-1:HALF] = word[HALF-1:0];
            else       rt_n[MASK_W-1:HALF] = word[HALF-1:0];
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q  <= CMD_ADDR; lock_q <= 1'b0; sel_q  <= 1'b0;
      row_q  <= '0;       col_q  <= '0;
      we_q   <= 1'b0;     wrow_q <= '0;   wcol_q <= '0;
      code_q <= '0;       attr_q <= 1'b0;
      vs_q   <= '0;       hs_q   <= '0;   flg_q  <= '0;
      mode_q <= '0;       rt_q   <= '0;   db_q   <= '0;
      port_q <= '0;
    end else begin
      cmd_q  <= cmd_n;    lock_q <= lock_n; sel_q  <= sel_n;
      row_q  <= row_n;    col_q  <= col_n;
      we_q   <= we_n;     wrow_q <= wrow_n; wcol_q <= wcol_n;
      code_q <= code_n;   attr_q <= attr_n;
      vs_q   <= vs_n;     hs_q   <= hs_n;   flg_q  <= flg_n;
      mode_q <= mode_n;   rt_q   <= rt_n;   db_q   <= db_n;
      port_q <= port_n;
    end
  end

  assign vram_we    = we_q;
  assign vram_row   = wrow_q;
  assign vram_col   = wcol_q;
  assign vram_code  = code_q;
  assign vram_attr  = attr_q;
  assign vstart     = vs_q;
  assign hstart     = hs_q;
  assign ctl_flags  = flg_q;
  assign disp_mode  = mode_q;
  assign route_mask = rt_q;
  assign dbl_mask   = db_q;
  assign gp_port    = port_q;

  // R7
  rel_to_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_rel |=> (cmd_q == CMD_ADDR && !lock_q));
  // R5
  wr_only_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vram_we |-> lock_q);
  // R6
  col_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (word_vld && lock_q && !sel_rel && col_q == COL_LAST) |=> (col_q == '0));
  // R3
  cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (word_vld && !word[7] && !lock_q && !sel_rel) |=> $stable(cmd_q));
  // R11
  port_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !word_vld |=> $stable(gp_port));
endmodule

// File: rtl/osd_serial_cmd.sv
module osd_serial_cmd #(
  parameter int SYNC_STAGES = 2,
  parameter int ROWS        = 12,
  parameter int COLS        = 24,
  parameter int POS_W       = 6,
  parameter int MASK_W      = 12,
  parameter int PORT_W      = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ser_sel_n,
  input  logic        ser_clk,
  input  logic        ser_dat,
  output logic        vram_we,
  output logic [3:0]  vram_row,
  output logic [4:0]  vram_col,
  output logic [6:0]  vram_code,
  output logic        vram_attr,
  output logic [5:0]  vstart,
  output logic [5:0]  hstart,
  output logic [3:0]  ctl_flags,
  output logic [6:0]  disp_mode,
  output logic [11:0] route_mask,
  output logic [11:0] dbl_mask,
  output logic [3:0]  gp_port
);
  logic       w_vld, w_rel;
  logic [7:0] w_data;

  osd_ser_shift #(.WORD_W(8), .SYNC_STAGES(SYNC_STAGES)) u_shift (
    .clk(clk), .rst_n(rst_n), .sel_n(ser_sel_n), .sclk(ser_clk),
    .sdat(ser_dat), .word_vld(w_vld), .word(w_data), .sel_rel(w_rel)
  );

  osd_cmd_dec #(
    .ROWS(ROWS), .COLS(COLS), .POS_W(POS_W), .MASK_W(MASK_W), .PORT_W(PORT_W)
  ) u_dec (
    .clk(clk), .rst_n(rst_n), .word_vld(w_vld), .word(w_data),
    .sel_rel(w_rel), .vram_we(vram_we), .vram_row(vram_row),
    .vram_col(vram_col), .vram_code(vram_code), .vram_attr(vram_attr),
    .vstart(vstart), .hstart(hstart), .ctl_flags(ctl_flags),
    .disp_mode(disp_mode), .route_mask(route_mask), .dbl_mask(dbl_mask),
    .gp_port(gp_port)
  );
endmodule

// File: tb/osd_serial_cmd_tb.sv
module osd_serial_cmd_tb;
  localparam int CLK_PERIOD = 10;
  localparam int HALF_BIT   = 4;

  logic clk, rst_n, sel_n, sclk, sdat;
  logic        vram_we, vram_attr;
  logic [3:0]  vram_row, ctl_flags, gp_port;
  logic [4:0]  vram_col;
  logic [6:0]  vram_code, disp_mode;
  logic [5:0]  vstart, hstart;
  logic [11:0] route_mask, dbl_mask;

  int errors = 0, checks = 0, wr_cnt = 0;
  logic [3:0] l_row; logic [4:0] l_col; logic [6:0] l_code; logic l_attr;
  logic [3:0] r_row [4]; logic [4:0] r_col [4]; logic [6:0] r_code [4];
  logic r_attr [4];

  osd_serial_cmd u_dut (
    .clk(clk), .rst_n(rst_n), .ser_sel_n(sel_n), .ser_clk(sclk),
    .ser_dat(sdat), .vram_we(vram_we), .vram_row(vram_row),
    .vram_col(vram_col), .vram_code(vram_code), .vram_attr(vram_attr),
    .vstart(vstart), .hstart(hstart), .ctl_flags(ctl_flags),
    .disp_mode(disp_mode), .route_mask(route_mask), .dbl_mask(dbl_mask),
    .gp_port(gp_port)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    if (rst_n && vram_we) begin
      if (wr_cnt < 4) begin
        r_row[wr_cnt] = vram_row; r_col[wr_cnt] = vram_col;
        r_code[wr_cnt] = vram_code; r_attr[wr_cnt] = vram_attr;
      end
      wr_cnt++;
    end
  end

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%0h expected=%0h", req, got, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bits(input logic [7:0] v, input int nbits);
    for (int i = 7; i > 7 - nbits; i--) begin
      sdat = v[i];
      wait_n(HALF_BIT);
      sclk = 1'b1;
      wait_n(HALF_BIT);
      sclk = 1'b0;
    end
    wait_n(6);
  endtask

  task automatic send(input logic [7:0] v);
    send_bits(v, 8);
  endtask

  task automatic sel_low;
    sel_n = 1'b0; wait_n(6);
  endtask

  task automatic sel_high;
    sel_n = 1'b1; wait_n(6);
  endtask

  task automatic finish_run;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog R1 got=timeout expected=completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; sel_n = 1'b1; sclk = 1'b0; sdat = 1'b0;
    wait_n(5);
    rst_n = 1'b1;
    wait_n(5);
    // R12 reset state
    chk("R12 we", vram_we, 0);
    chk("R12 regs", {vstart, hstart, ctl_flags, disp_mode, gp_port}, 0);
    chk("R12 masks", {route_mask, dbl_mask}, 0);

    // R1 partial word dropped on select release
    sel_low(); send_bits(8'hFF, 3); sel_high();
    sel_low(); send(8'hE5);
    chk("R1 realign port", gp_port, 4'h5);

    // R11 / R2 port sweep
    for (int p = 0; p < 16; p++) begin
      send(8'hE0 | 8'(p));
      chk("R11 port", gp_port, p);
    end

    // R8 / R3 vertical and horizontal sweeps, one command per sweep
    send(8'hA0);
    for (int v = 0; v < 64; v++) begin
      send(8'(v)); chk("R8 vstart", vstart, v);
    end
    send(8'hB0);
    for (int v = 0; v < 64; v++) begin
      send(8'(63 - v)); chk("R8 hstart", hstart, 63 - v);
    end
    chk("R3 vstart kept", vstart, 63);

    // R9 flags and display mode
    for (int f = 0; f < 16; f++) begin
      send(8'hC0 | 8'(f)); chk("R9 flags", ctl_flags, f);
    end
    for (int m = 0; m < 128; m++) begin
      send(8'(m)); chk("R9 mode", disp_mode, m);
    end

    // R10 masks, both select values and both halves
    send(8'hD0);
    for (int x = 0; x < 64; x++) begin
      send(8'(x)); chk("R10 route lo", route_mask[5:0], x);
    end
    send(8'hE3);
    chk("R11 port via mask cmd", gp_port, 3);
    for (int x = 0; x < 64; x++) begin
      send(8'(x ^ 21)); chk("R10 route hi", route_mask[11:6], x ^ 21);
    end
    chk("R10 route lo kept", route_mask[5:0], 63);
    chk("R10 dbl untouched", dbl_mask, 0);
    send(8'hD1); send(8'h2D);
    send(8'hE3); send(8'h12);
    chk("R10 dbl", dbl_mask, {6'h12, 6'h2D});
    chk("R10 route kept", route_mask, {6'(63 ^ 21), 6'd63});

    // R13 command 7 data ignored
    send(8'hF0); send(8'h2A); send(8'h15);
    chk("R13 pos", {vstart, hstart}, {6'd63, 6'd0});
    chk("R13 mode", disp_mode, 127);
    chk("R13 port", gp_port, 3);
    chk("R13 masks", {route_mask, dbl_mask}, {6'(63 ^ 21), 6'd63, 6'h12, 6'h2D});

    // R4 R5 R6 stream across column wrap
    sel_high(); sel_low();
    send(8'h82); send(8'h16);
    chk("R4 no write on address", wr_cnt, 0);
    send(8'h90); send(8'h41); send(8'hA5); send(8'h7F);
    chk("R5 write count", wr_cnt, 3);
    chk("R4 first addr", {r_row[0], r_col[0]}, {4'd2, 5'd22});
    chk("R5 first data", {r_attr[0], r_code[0]}, 8'h41);
    chk("R6 second addr", {r_row[1], r_col[1]}, {4'd2, 5'd23});
    chk("R5 bit7 as attr", {r_attr[1], r_code[1]}, 8'hA5);
    chk("R6 col wrap", {r_row[2], r_col[2]}, {4'd3, 5'd0});
    chk("R5 vstart untouched", vstart, 63);

    // R7 release returns to address mode
    sel_high(); sel_low();
    wr_cnt = 0;
    send(8'h07); send(8'h90); send(8'h11);
    chk("R7 col loaded after release", {r_row[0], r_col[0], r_code[0]}, {4'd3, 5'd7, 7'h11});

    // R6 row wrap
    sel_high(); sel_low();
    wr_cnt = 0;
    send(8'h8B); send(8'h17); send(8'h90); send(8'h01); send(8'h02);
    chk("R6 row wrap count", wr_cnt, 2);
    chk("R6 last cell", {r_row[0], r_col[0]}, {4'd11, 5'd23});
    chk("R6 row wrap", {r_row[1], r_col[1]}, {4'd0, 5'd0});

    sel_high(); sel_low();
    send(8'hE9);
    chk("R7 commands after release", gp_port, 9);
    chk("R7 no stray write", wr_cnt, 2);
    sel_high();
    finish_run();
  end
endmodule